// File: doc/BRIEF.md
# APB Register-File Completer

This block is an APB completer that holds a bank of sixteen word-wide registers. A requester reaches it with the usual two-phase transfer. First comes a setup cycle with select high and enable low. Then comes an access cycle with both high. Writes store the write data into the addressed register. Reads return the stored word. An access whose address falls outside the bank completes with an error response, leaves the bank unchanged and returns zero.

A parameter selects one of two timing modes. In the default zero-wait mode, the register index and the range check are captured at the end of the setup cycle. Read data can then be driven straight from that captured index during the access cycle, and the ready output stays high all the time, so every transfer takes exactly two cycles. In the late-sampling mode, the address of a read is taken during its first access cycle. Ready is held low for that one cycle, and the data, ready and error come out together in the cycle after. Writes never wait in either mode.

Top module: `regbank_apb`

## Requirements
- R1: The bank has NUM_REGS=16 registers addressed by byte address. PADDR[5:2] selects the register, PADDR[1:0] are ignored, and any nonzero bit in PADDR[7:6] makes the access out of range.
- R2: A write to an in-range address stores PWDATA into the selected register, and a later read of that register returns the stored value.
- R3: With ACCESS_SAMPLE=0, PREADY is high in every cycle, and a read returns valid data in its first access cycle, so every transfer takes two cycles.
- R4: With ACCESS_SAMPLE=1, a read holds PREADY low for exactly its first access cycle. PREADY, PRDATA and PSLVERR are then presented together in the second access cycle.
- R5: In both modes a write completes in its first access cycle with PREADY high.
- R6: An out-of-range access drives PSLVERR high in its completing cycle, leaves every register unchanged and returns zero on PRDATA.
- R7: PSLVERR is low whenever PREADY is low, and whenever the block is not in an access cycle (PSEL and PENABLE both high).
- R8: PRDATA is zero in every cycle except the completing cycle of a read.
- R9: While PRESETn is low, all registers are cleared to zero and the read wait logic returns to idle.
- R10: A new setup cycle may follow a completed access cycle directly, with no idle cycle in between, and each transfer still behaves as stated above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pClk | input | 1 | Bus clock |
| pResetN | input | 1 | Active-low asynchronous reset |
| pSel | input | 1 | Completer select |
| pEnable | input | 1 | High in access cycles |
| pWrite | input | 1 | 1 = write, 0 = read |
| pAddr | input | ADDR_W (8) | Byte address |
| pWData | input | DATA_W (32) | Write data |
| pRData | output | DATA_W (32) | Read data, zero outside a completing read |
| pReady | output | 1 | Transfer completes in this access cycle when high |
| pSlvErr | output | 1 | Error response for an out-of-range access |

## Verification
The assertions check the handshake shape on every cycle: ready always high in zero-wait mode, exactly one wait cycle on late-sampled reads, writes that never wait, error only in completing cycles, and zero read data outside completing reads and on errors. Data integrity can only be shown by the bench's scenarios. Those scenarios cover stored values read back after writes, out-of-range writes that must not alias onto a real register, ignored low address bits, clearing by reset in the middle of a run, and transfers issued back to back with no idle gap.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Strobes from the control FSM to the register datapath
  typedef struct packed {
    logic capture;  // latch index and range flag from the live address
    logic useLive;  // decode the live address instead of the captured one
    logic wrEn;     // commit write data this cycle
    logic rdDrive;  // drive read data this cycle
  } bankStrobe_t;

endpackage

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
#(
  parameter bit ACCESS_SAMPLE = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pSel,
  input  logic        pEnable,
  input  logic        pWrite,
  input  logic        addrErr,
  output bankStrobe_t strobe,
  output logic        pReady,
  output logic        pSlvErr
);

  logic setupPh;
  logic accessPh;

  assign setupPh  = pSel & ~pEnable;
  assign accessPh = pSel & pEnable;

  generate
    if (ACCESS_SAMPLE) begin : g_late
      logic waitQ;   // a read has spent its wait cycle
      logic rdFirst; // first access cycle of a read

      assign rdFirst = accessPh & ~pWrite & ~waitQ;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) waitQ <= 1'b0;
        else       waitQ <= rdFirst;
      end

      always_comb begin
        strobe.capture = rdFirst;
        strobe.useLive = pWrite;
        strobe.wrEn    = accessPh & pWrite;
        strobe.rdDrive = accessPh & ~pWrite & waitQ;
        pReady         = ~rdFirst;
      end
    end else begin : g_early
      always_comb begin
        strobe.capture = setupPh;
        strobe.useLive = 1'b0;
        strobe.wrEn    = accessPh & pWrite;
        strobe.rdDrive = accessPh & ~pWrite;
        pReady         = 1'b1;
      end
    end
  endgenerate

  assign pSlvErr = accessPh & pReady & addrErr;

endmodule

// File: rtl/regbank_dpath.sv
module regbank_dpath
  import regbank_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strobe,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [DATA_W-1:0] pWData,
  output logic              addrErr,
  output logic [DATA_W-1:0] pRData
);

  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic [IDX_W-1:0]  liveIdx;
  logic [IDX_W-1:0]  capIdx;
  logic [IDX_W-1:0]  selIdx;
  logic              liveErr;
  logic              capErr;
  logic [NUM_REGS-1:0] wrHit;
  logic [DATA_W-1:0] bank [NUM_REGS];

  assign liveIdx = pAddr[IDX_HI:IDX_LO];
  assign liveErr = |pAddr[ADDR_W-1:IDX_HI+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capIdx <= '0;
      capErr <= 1'b0;
    end else if (strobe.capture) begin
      capIdx <= liveIdx;
      capErr <= liveErr;
    end
  end

  assign selIdx  = strobe.useLive ? liveIdx : capIdx;
  assign addrErr = strobe.useLive ? liveErr : capErr;

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
      assign wrHit[i] = strobe.wrEn & ~addrErr & (selIdx == IDX_W'(i));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) bank[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (wrHit[i]) bank[i] <= pWData;
    end
  end

  assign pRData = (strobe.rdDrive && !addrErr) ? bank[selIdx] : '0;

endmodule

// File: rtl/regbank_apb.sv
module regbank_apb
  import regbank_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 8,
  parameter int NUM_REGS      = 16,
  parameter bit ACCESS_SAMPLE = 1'b0
) (
  input  logic              pClk,
  input  logic              pResetN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddr,
  input  logic [DATA_W-1:0] pWData,
  output logic [DATA_W-1:0] pRData,
  output logic              pReady,
  output logic              pSlvErr
);

  bankStrobe_t strobe;
  logic        addrErr;

  regbank_ctrl #(.ACCESS_SAMPLE(ACCESS_SAMPLE)) u_ctrl (
    .clk     (pClk),
    .rstN    (pResetN),
    .pSel    (pSel),
    .pEnable (pEnable),
    .pWrite  (pWrite),
    .addrErr (addrErr),
    .strobe  (strobe),
    .pReady  (pReady),
    .pSlvErr (pSlvErr)
  );

  regbank_dpath #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) u_dpath (
    .clk     (pClk),
    .rstN    (pResetN),
    .strobe  (strobe),
    .pAddr   (pAddr),
    .pWData  (pWData),
    .addrErr (addrErr),
    .pRData  (pRData)
  );

endmodule

// File: rtl/regbank_apb_chk.sv
module regbank_apb_chk #(
  parameter int DATA_W        = 32,
  parameter int ADDR_W        = 8,
  parameter int NUM_REGS      = 16,
  parameter bit ACCESS_SAMPLE = 1'b0
) (
  input logic              pClk,
  input logic              pResetN,
  input logic              pSel,
  input logic              pEnable,
  input logic              pWrite,
  input logic [ADDR_W-1:0] pAddr,
  input logic [DATA_W-1:0] pRData,
  input logic              pReady,
  input logic              pSlvErr
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic accessPh;
  logic done;
  logic oor;

  assign accessPh = pSel & pEnable;
  assign done     = accessPh & pReady;
  assign oor      = |pAddr[ADDR_W-1:IDX_W+2];

  // R5
  write_no_wait_chk: assert property (@(posedge pClk) disable iff (!pResetN)
    (accessPh && pWrite) |-> pReady);

  // R6
  err_zero_data_chk: assert property (@(posedge pClk) disable iff (!pResetN)
    pSlvErr |-> (pRData == '0));

  // R6
  err_on_range_chk: assert property (@(posedge pClk) disable iff (!pResetN)
    done |-> (pSlvErr == oor));

  // R7
  err_only_done_chk: assert property (@(posedge pClk) disable iff (!pResetN)
    pSlvErr |-> done);

  // R8
  rdata_idle_zero_chk: assert property (@(posedge pClk) disable iff (!pResetN)
    !(done && !pWrite) |-> (pRData == '0));

  generate
    if (ACCESS_SAMPLE) begin : g_late
      // R4
      read_one_wait_chk: assert property (@(posedge pClk) disable iff (!pResetN)
        (accessPh && !pWrite && !pReady) |=> (!(pSel && pEnable) || pReady));
      // R4
      read_waits_chk: assert property (@(posedge pClk) disable iff (!pResetN)
        (pSel && !pEnable) |=> (!(pSel && pEnable && !pWrite) || !pReady));
    end else begin : g_early
      // R3
      ready_high_chk: assert property (@(posedge pClk) disable iff (!pResetN)
        pReady);
    end
  endgenerate

endmodule

bind regbank_apb regbank_apb_chk #(
  .DATA_W        (DATA_W),
  .ADDR_W        (ADDR_W),
  .NUM_REGS      (NUM_REGS),
  .ACCESS_SAMPLE (ACCESS_SAMPLE)
) u_chk (
  .pClk    (pClk),
  .pResetN (pResetN),
  .pSel    (pSel),
  .pEnable (pEnable),
  .pWrite  (pWrite),
  .pAddr   (pAddr),
  .pRData  (pRData),
  .pReady  (pReady),
  .pSlvErr (pSlvErr)
);

// File: tb/test_regbank_apb.sv
`timescale 1ns/1ps
module test_regbank_apb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel   [2];
  logic        en    [2];
  logic        wr    [2];
  logic [7:0]  addr  [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];
  logic        ready [2];
  logic        err   [2];

  logic [31:0] model [2][16];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  // instance 0: zero-wait mode, instance 1: late-sampling mode
  regbank_apb #(.ACCESS_SAMPLE(1'b0)) i_regbank_apb (
    .pClk(clk), .pResetN(rstN), .pSel(sel[0]), .pEnable(en[0]), .pWrite(wr[0]),
    .pAddr(addr[0]), .pWData(wdata[0]), .pRData(rdata[0]), .pReady(ready[0]),
    .pSlvErr(err[0]));

  regbank_apb #(.ACCESS_SAMPLE(1'b1)) i_regbank_apb_late (
    .pClk(clk), .pResetN(rstN), .pSel(sel[1]), .pEnable(en[1]), .pWrite(wr[1]),
    .pAddr(addr[1]), .pWData(wdata[1]), .pRData(rdata[1]), .pReady(ready[1]),
    .pSlvErr(err[1]));

  function automatic bit inRange(input logic [7:0] a);
    return a[7:6] == 2'b00;
  endfunction

  function automatic logic [31:0] expRead(input int m, input logic [7:0] a);
    return inRange(a) ? model[m][a[5:2]] : 32'h0;
  endfunction

  function automatic int expWaits(input int m, input bit w);
    return (m == 1 && !w) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic idleBus(input int m);
    @(negedge clk);
    sel[m] = 1'b0; en[m] = 1'b0;
  endtask

  // Drives one transfer. Returns at the completing access cycle,
  // after the outputs have been sampled; the next edge ends the transfer.
  task automatic xfer(input int m, input bit w, input logic [7:0] a,
                      input logic [31:0] d);
    int waits = 0;
    @(negedge clk);
    sel[m] = 1'b1; en[m] = 1'b0; wr[m] = w; addr[m] = a; wdata[m] = d;
    #1;
    chk("R8", "setup rdata", rdata[m], 32'h0);
    chk("R7", "setup slverr", 32'(err[m]), 32'h0);
    @(negedge clk);
    en[m] = 1'b1;
    #1;
    while (!ready[m] && waits < 4) begin
      chk("R7", "wait slverr", 32'(err[m]), 32'h0);
      chk("R8", "wait rdata", rdata[m], 32'h0);
      waits++;
      @(negedge clk);
      #1;
    end
    chk(m == 0 ? "R3" : (w ? "R5" : "R4"), "wait cycles",
        32'(waits), 32'(expWaits(m, w)));
    chk("R6", "slverr", 32'(err[m]), 32'(!inRange(a)));
    if (w) begin
      chk("R8", "rdata on write", rdata[m], 32'h0);
      if (inRange(a)) model[m][a[5:2]] = d;
    end else begin
      chk(inRange(a) ? "R2" : "R6", "read data", rdata[m], expRead(m, a));
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    for (int m = 0; m < 2; m++) begin
      sel[m] = 1'b0; en[m] = 1'b0; wr[m] = 1'b0; addr[m] = '0; wdata[m] = '0;
      for (int i = 0; i < 16; i++) model[m][i] = '0;
    end
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [7:0] randAddr();
    logic [1:0] hi = ($urandom_range(0, 7) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
    return {hi, 4'($urandom_range(0, 15)), 2'($urandom_range(0, 3))};
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unused = $urandom(32'h5eed_1234);
    doReset();
    #1;
    for (int m = 0; m < 2; m++) begin
      chk("R9", "idle rdata", rdata[m], 32'h0);
      chk("R7", "idle slverr", 32'(err[m]), 32'h0);
      chk("R9", "idle ready", 32'(ready[m]), 32'h1);
    end

    for (int m = 0; m < 2; m++) begin
      // R9: bank cleared by reset
      for (int i = 0; i < 16; i++) xfer(m, 1'b0, 8'(i << 2), '0);
      idleBus(m);
      // R1: low address bits ignored
      xfer(m, 1'b1, 8'h3F, 32'hA5A5_0F0F);
      idleBus(m);
      xfer(m, 1'b0, 8'h3C, '0);
      xfer(m, 1'b0, 8'h3E, '0);
      idleBus(m);
      // R6: out-of-range write must not alias onto register 3
      xfer(m, 1'b1, 8'h0C, 32'h1111_2222);
      xfer(m, 1'b1, 8'h4C, 32'hDEAD_BEEF);
      xfer(m, 1'b0, 8'h0C, '0);
      xfer(m, 1'b0, 8'hCC, '0);
      idleBus(m);
      // R10: back-to-back write then read of the same and another register
      xfer(m, 1'b1, 8'h20, 32'h0BAD_F00D);
      xfer(m, 1'b0, 8'h20, '0);
      xfer(m, 1'b1, 8'h24, 32'hCAFE_0001);
      xfer(m, 1'b0, 8'h24, '0);
      xfer(m, 1'b0, 8'h20, '0);
      idleBus(m);
      // random mix (R2, R6, R10)
      for (int n = 0; n < 300; n++) begin
        xfer(m, 1'($urandom_range(0, 1)), randAddr(), $urandom());
        if ($urandom_range(0, 2) == 0) idleBus(m);
      end
      idleBus(m);
    end

    // R9: reset in the middle of a run clears everything in both modes
    doReset();
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 16; i++) xfer(m, 1'b0, 8'(i << 2), '0);
      idleBus(m);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule